// File: doc/BRIEF.md
# Load-Tracking Current Reference Scheduler

This block sets one shared current target for a group of battery modules wired in parallel. Each module runs its own fast current loop. The loop reports back an 8-bit duty code for its step-down converter and a 10-bit measured current. On every pulse of a slow update strobe the block looks at all duty codes and all currents and moves the shared target.

The goal is the largest target at which one module just reaches full duty while the module currents still agree. While searching, the target climbs at an initial rate when no module is saturated. When a module is saturated but the currents disagree, the target is lowered at a slow rate. Once a module is at full duty and the currents agree, the block parks in an idle state and holds the target. It leaves idle when the load changes. In that case it moves the target at a fast rate, either up (a duty code has dropped under the high-duty threshold) or down (the current spread has grown), and searches again.

Each module receives its own copy of the target, scaled by an unsigned capacity factor. This lets a module with less stored charge carry a smaller share of the load.

Top module: `ldtrk_ref_sched`

## Requirements
- R1: After reset the target `ref_o` is 0, `idle_o` is 0 (search state) and every scaled output is 0.
- R2: The target and the state change only on a clock edge where `upd_i` is 1; on all other edges they hold.
- R3: In search with no duty code equal to 255, an update adds `rate_init_i` to the target, saturating at 1023, and the block stays in search.
- R4: In search, when at least one duty code equals 255 and the current spread (largest minus smallest module current) is below `thr_i`, an update enters idle (`idle_o`=1) and leaves the target unchanged.
- R5: In search, when a duty code equals 255 and the spread is at least `thr_i`, an update subtracts `rate_slow_i`, saturating at 0, and the block stays in search.
- R6: In idle, when any duty code is below 230, an update adds `rate_fast_i` (saturating at 1023) and returns to search.
- R7: In idle, when every duty code is at least 230 and the spread is greater than `thr_i`, an update subtracts `rate_fast_i` (saturating at 0) and returns to search.
- R8: In idle, when every duty code is at least 230 and the spread is at most `thr_i`, an update holds both the target and the idle state.
- R9: Module k's scaled output `mod_ref_o[k*11 +: 11]` equals floor(`ref_o` × s / 256), where s is the unsigned Q1.8 factor `scale_i[k*9 +: 9]`. Module k's duty code is `duty_i[k*8 +: 8]` and its current is `cur_i[k*10 +: 10]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Single-cycle slow update strobe |
| duty_i | input | 24 | Per-module duty codes, module k at bits k*8 |
| cur_i | input | 30 | Per-module measured currents, module k at bits k*10 |
| thr_i | input | 10 | Current spread threshold |
| rate_init_i | input | 10 | Step used while searching upward |
| rate_fast_i | input | 10 | Step used when leaving idle |
| rate_slow_i | input | 10 | Step used while backing off in search |
| scale_i | input | 27 | Per-module Q1.8 capacity factors |
| ref_o | output | 10 | Shared current target |
| mod_ref_o | output | 33 | Per-module scaled targets, module k at bits k*11 |
| idle_o | output | 1 | High while the scheduler is parked |

## Verification
The main sweep covers every mix of the duty codes 0, 229, 230, 254 and 255 over three modules. Each mix is applied at spreads one below, equal to and one above the threshold, with the widest current placed in a rotating module. This separates the full-duty test from the high-duty test, and the strict comparison from the inclusive one, in both states. Directed runs drive the target into both saturation limits and hold inputs steady with the strobe low. Scaled outputs are compared after every update for factors below, at and above one.

// File: rtl/ldtrk_pkg.sv
package ldtrk_pkg;
   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_IDLE   = 1'b1
   } sched_st_e;
endpackage

// File: rtl/ldtrk_mod_eval.sv
module ldtrk_mod_eval #(
   parameter int N_MOD     = 3,
   parameter int DUTY_W    = 8,
   parameter int CUR_W     = 10,
   parameter int FULL_CODE = 255,
   parameter int HIGH_CODE = 230
) (
   input  logic [N_MOD*DUTY_W-1:0] duty_i,
   input  logic [N_MOD*CUR_W-1:0]  cur_i,
   output logic                    any_full_o,
   output logic                    any_low_o,
   output logic [CUR_W-1:0]        spread_o
);
   localparam logic [DUTY_W-1:0] FULL_V = DUTY_W'(FULL_CODE);
   localparam logic [DUTY_W-1:0] HIGH_V = DUTY_W'(HIGH_CODE);

   logic [CUR_W-1:0] cmax, cmin;

   always_comb begin
      any_full_o = 1'b0;
      any_low_o  = 1'b0;
      cmax       = '0;
      cmin       = '1;
      for (int k = 0; k < N_MOD; k++) begin
         if (duty_i[k*DUTY_W +: DUTY_W] == FULL_V) any_full_o = 1'b1;
         if (duty_i[k*DUTY_W +: DUTY_W] <  HIGH_V) any_low_o  = 1'b1;
         if (cur_i[k*CUR_W +: CUR_W] > cmax) cmax = cur_i[k*CUR_W +: CUR_W];
         if (cur_i[k*CUR_W +: CUR_W] < cmin) cmin = cur_i[k*CUR_W +: CUR_W];
      end
      spread_o = cmax - cmin;
   end
endmodule

// File: rtl/ldtrk_ref_scale.sv
module ldtrk_ref_scale #(
   parameter int N_MOD     = 3,
   parameter int REF_W     = 10,
   parameter int SCL_W     = 9,
   parameter int SCL_FRAC  = 8,
   parameter bit USE_SCALE = 1'b1,
   localparam int OUT_W    = REF_W + SCL_W - SCL_FRAC,
   localparam int PROD_W   = REF_W + SCL_W
) (
   input  logic [REF_W-1:0]       ref_i,
   input  logic [N_MOD*SCL_W-1:0] scale_i,
   output logic [N_MOD*OUT_W-1:0] mod_ref_o
);
   for (genvar k = 0; k < N_MOD; k++) begin : g_mod
      if (USE_SCALE) begin : g_scaled
         logic [PROD_W-1:0] prod;
         assign prod = PROD_W'(ref_i) * PROD_W'(scale_i[k*SCL_W +: SCL_W]);
         assign mod_ref_o[k*OUT_W +: OUT_W] = OUT_W'(prod >> SCL_FRAC);
      end else begin : g_plain
         assign mod_ref_o[k*OUT_W +: OUT_W] = OUT_W'(ref_i);
      end
   end
endmodule

// File: rtl/ldtrk_ref_sched.sv
module ldtrk_ref_sched
   import ldtrk_pkg::*;
#(
   parameter int N_MOD     = 3,
   parameter int DUTY_W    = 8,
   parameter int CUR_W     = 10,
   parameter int REF_W     = 10,
   parameter int SCL_W     = 9,
   parameter int SCL_FRAC  = 8,
   parameter int FULL_CODE = 255,
   parameter int HIGH_CODE = 230,
   parameter bit USE_SCALE = 1'b1,
   localparam int OUT_W    = REF_W + SCL_W - SCL_FRAC
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_i,
   input  logic [N_MOD*DUTY_W-1:0] duty_i,
   input  logic [N_MOD*CUR_W-1:0]  cur_i,
   input  logic [CUR_W-1:0]        thr_i,
   input  logic [REF_W-1:0]        rate_init_i,
   input  logic [REF_W-1:0]        rate_fast_i,
   input  logic [REF_W-1:0]        rate_slow_i,
   input  logic [N_MOD*SCL_W-1:0]  scale_i,
   output logic [REF_W-1:0]        ref_o,
   output logic [N_MOD*OUT_W-1:0]  mod_ref_o,
   output logic                    idle_o
);
   // elaboration-time parameter checks
   if (N_MOD < 2) begin : g_bad_n
      $error("ldtrk_ref_sched: N_MOD must be at least 2");
   end
   if (FULL_CODE > (2**DUTY_W) - 1) begin : g_bad_full
      $error("ldtrk_ref_sched: FULL_CODE does not fit DUTY_W");
   end
   if (HIGH_CODE >= FULL_CODE) begin : g_bad_high
      $error("ldtrk_ref_sched: HIGH_CODE must be below FULL_CODE");
   end
   if (SCL_W <= SCL_FRAC) begin : g_bad_scl
      $error("ldtrk_ref_sched: SCL_W must exceed SCL_FRAC");
   end

   sched_st_e        st_q, st_nx;
   logic [REF_W-1:0] ref_q, ref_nx;
   logic             any_full, any_low;
   logic [CUR_W-1:0] spread;

   function automatic logic [REF_W-1:0] sat_up(input logic [REF_W-1:0] a,
                                               input logic [REF_W-1:0] b);
      logic [REF_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[REF_W] ? '1 : s[REF_W-1:0];
   endfunction

   function automatic logic [REF_W-1:0] sat_dn(input logic [REF_W-1:0] a,
                                               input logic [REF_W-1:0] b);
      return (b > a) ? '0 : a - b;
   endfunction

   ldtrk_mod_eval #(
      .N_MOD(N_MOD), .DUTY_W(DUTY_W), .CUR_W(CUR_W),
      .FULL_CODE(FULL_CODE), .HIGH_CODE(HIGH_CODE)
   ) i_eval (
      .duty_i(duty_i), .cur_i(cur_i),
      .any_full_o(any_full), .any_low_o(any_low), .spread_o(spread)
   );

   always_comb begin
      st_nx  = st_q;
      ref_nx = ref_q;
      unique case (st_q)
         ST_SEARCH: begin
            if (!any_full) begin
               ref_nx = sat_up(ref_q, rate_init_i);
            end else if (spread < thr_i) begin
               st_nx = ST_IDLE;
            end else begin
               ref_nx = sat_dn(ref_q, rate_slow_i);
            end
         end
         ST_IDLE: begin
            if (any_low) begin
               ref_nx = sat_up(ref_q, rate_fast_i);
               st_nx  = ST_SEARCH;
            end else if (spread > thr_i) begin
               ref_nx = sat_dn(ref_q, rate_fast_i);
               st_nx  = ST_SEARCH;
            end
         end
         default: st_nx = ST_SEARCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_SEARCH;
         ref_q <= '0;
      end else if (upd_i) begin
         st_q  <= st_nx;
         ref_q <= ref_nx;
      end
   end

   ldtrk_ref_scale #(
      .N_MOD(N_MOD), .REF_W(REF_W), .SCL_W(SCL_W),
      .SCL_FRAC(SCL_FRAC), .USE_SCALE(USE_SCALE)
   ) i_scale (
      .ref_i(ref_q), .scale_i(scale_i), .mod_ref_o(mod_ref_o)
   );

   assign ref_o  = ref_q;
   assign idle_o = (st_q == ST_IDLE);
endmodule

// File: rtl/ldtrk_ref_sched_chk.sv
module ldtrk_ref_sched_chk #(
   parameter int N_MOD     = 3,
   parameter int DUTY_W    = 8,
   parameter int CUR_W     = 10,
   parameter int REF_W     = 10,
   parameter int FULL_CODE = 255,
   parameter int HIGH_CODE = 230
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    upd_i,
   input logic [N_MOD*DUTY_W-1:0] duty_i,
   input logic [N_MOD*CUR_W-1:0]  cur_i,
   input logic [CUR_W-1:0]        thr_i,
   input logic [REF_W-1:0]        ref_o,
   input logic                    idle_o
);
   logic c_full, c_low;
   int   c_hi, c_lo, c_spread;

   always_comb begin
      c_full = 1'b0;
      c_low  = 1'b0;
      c_hi   = 0;
      c_lo   = 1 << CUR_W;
      for (int k = 0; k < N_MOD; k++) begin
         if (int'(duty_i[k*DUTY_W +: DUTY_W]) == FULL_CODE) c_full = 1'b1;
         if (int'(duty_i[k*DUTY_W +: DUTY_W]) <  HIGH_CODE) c_low  = 1'b1;
         if (int'(cur_i[k*CUR_W +: CUR_W]) > c_hi) c_hi = int'(cur_i[k*CUR_W +: CUR_W]);
         if (int'(cur_i[k*CUR_W +: CUR_W]) < c_lo) c_lo = int'(cur_i[k*CUR_W +: CUR_W]);
      end
      c_spread = c_hi - c_lo;
   end

   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(ref_o) && $stable(idle_o));

   a_r3_search_climbs: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && upd_i && !c_full) |=> !idle_o && (ref_o >= $past(ref_o)));

   a_r4_park_on_balance: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && upd_i && c_full && (c_spread < int'(thr_i))) |=> idle_o && $stable(ref_o));

   a_r5_search_backs_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && upd_i && c_full && (c_spread >= int'(thr_i))) |=> !idle_o && (ref_o <= $past(ref_o)));

   a_r6_idle_leaves_up: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && upd_i && c_low) |=> !idle_o && (ref_o >= $past(ref_o)));

   a_r7_idle_leaves_down: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && upd_i && !c_low && (c_spread > int'(thr_i))) |=> !idle_o && (ref_o <= $past(ref_o)));

   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && upd_i && !c_low && (c_spread <= int'(thr_i))) |=> idle_o && $stable(ref_o));
endmodule

bind ldtrk_ref_sched ldtrk_ref_sched_chk #(
   .N_MOD(N_MOD), .DUTY_W(DUTY_W), .CUR_W(CUR_W), .REF_W(REF_W),
   .FULL_CODE(FULL_CODE), .HIGH_CODE(HIGH_CODE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .duty_i(duty_i), .cur_i(cur_i),
   .thr_i(thr_i), .ref_o(ref_o), .idle_o(idle_o)
);

// File: tb/test_ldtrk_ref_sched.sv
module test_ldtrk_ref_sched;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 3;
   localparam int RW  = 10;
   localparam int OW  = 11;
   localparam int MAXR = 1023;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          upd = 1'b0;
   logic [N*8-1:0]  duty = '0;
   logic [N*10-1:0] cur = '0;
   logic [9:0]    thr = 10'd40;
   logic [RW-1:0] r_init = 10'd37, r_fast = 10'd90, r_slow = 10'd13;
   logic [N*9-1:0]  scl = '0;
   logic [RW-1:0] ref_o;
   logic [N*OW-1:0] mref;
   logic          idle_o;

   int checks = 0, errors = 0;
   int m_ref = 0;
   bit m_idle = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldtrk_ref_sched i_ldtrk_ref_sched (
      .clk(clk), .rst_n(rst_n), .upd_i(upd), .duty_i(duty), .cur_i(cur),
      .thr_i(thr), .rate_init_i(r_init), .rate_fast_i(r_fast),
      .rate_slow_i(r_slow), .scale_i(scl), .ref_o(ref_o),
      .mod_ref_o(mref), .idle_o(idle_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_scales(input int s0, input int s1, input int s2);
      scl = {9'(s2), 9'(s1), 9'(s0)};
   endtask

   task automatic check_outputs(input string tag);
      chk({tag, " ref"}, int'(ref_o), m_ref);
      chk({tag, " idle"}, int'(idle_o), int'(m_idle));
      for (int k = 0; k < N; k++)
         chk("R9 scaled", int'(mref[k*OW +: OW]), (m_ref * int'(scl[k*9 +: 9])) >> 8);
   endtask

   // drive duty codes and a current set with spread sp, largest current in module rot
   task automatic apply(input int d0, input int d1, input int d2, input int sp, input int rot);
      int c[3];
      c[rot % 3]       = 300 + sp;
      c[(rot + 1) % 3] = 300;
      c[(rot + 2) % 3] = 300 + sp / 2;
      duty = {8'(d2), 8'(d1), 8'(d0)};
      cur  = {10'(c[2]), 10'(c[1]), 10'(c[0])};
   endtask

   task automatic do_tick(input int d0, input int d1, input int d2, input int sp, input int rot);
      string tag;
      bit anyf, anyl;
      apply(d0, d1, d2, sp, rot);
      anyf = (d0 == 255) || (d1 == 255) || (d2 == 255);
      anyl = (d0 < 230) || (d1 < 230) || (d2 < 230);
      if (!m_idle) begin
         if (!anyf) begin
            tag = "R3"; m_ref = (m_ref + int'(r_init) > MAXR) ? MAXR : m_ref + int'(r_init);
         end else if (sp < int'(thr)) begin
            tag = "R4"; m_idle = 1'b1;
         end else begin
            tag = "R5"; m_ref = (int'(r_slow) > m_ref) ? 0 : m_ref - int'(r_slow);
         end
      end else begin
         if (anyl) begin
            tag = "R6"; m_idle = 1'b0;
            m_ref = (m_ref + int'(r_fast) > MAXR) ? MAXR : m_ref + int'(r_fast);
         end else if (sp > int'(thr)) begin
            tag = "R7"; m_idle = 1'b0;
            m_ref = (int'(r_fast) > m_ref) ? 0 : m_ref - int'(r_fast);
         end else begin
            tag = "R8";
         end
      end
      upd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      upd = 1'b0;
      check_outputs(tag);
   endtask

   initial begin
      int dv[5] = '{0, 229, 230, 254, 255};
      set_scales(256, 205, 205);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outputs("R1 reset");

      // R3: climb to the upper saturation limit
      for (int i = 0; i < 30; i++) do_tick(100, 120, 140, 0, i);
      chk("R3 saturated top", int'(ref_o), MAXR);

      // R2: no strobe, inputs change, nothing moves
      for (int i = 0; i < 5; i++) begin
         apply(255, 255, 255, 500, i);
         @(negedge clk);
         check_outputs("R2 no strobe");
      end

      // R5 at spread equal to threshold, then R4 just under it
      do_tick(255, 10, 10, 40, 0);
      do_tick(10, 255, 10, 41, 1);
      do_tick(10, 10, 255, 39, 2);
      chk("R4 parked", int'(idle_o), 1);
      // R8 at spread equal to threshold, R6 with one duty at 229
      do_tick(230, 230, 255, 40, 0);
      do_tick(230, 229, 255, 0, 1);
      do_tick(255, 240, 240, 0, 2);
      // R7 at spread one above threshold
      do_tick(230, 230, 230, 41, 0);

      // R5 down to the lower saturation limit
      r_slow = 10'd600;
      for (int i = 0; i < 3; i++) do_tick(255, 0, 0, 200, i);
      chk("R5 saturated bottom", int'(ref_o), 0);
      r_slow = 10'd13;

      // sweep: every duty mix at spreads thr-1, thr, thr+1
      for (int i = 0; i < 125; i++) begin
         if (i % 25 == 0) set_scales(256 + i, 205 - i, 511 - 3 * i);
         for (int s = 0; s < 3; s++)
            do_tick(dv[i % 5], dv[(i / 5) % 5], dv[i / 25], int'(thr) - 1 + s, i + s);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule